// File: doc/BRIEF.md
# Indexed block register target for a two-wire management bus

This block is an SMBus target that lets a host read and write a small bank of 8-bit configuration registers. Every transfer moves a block of bytes starting at a register index. The bus lines are brought into the system clock domain through flop synchronizers. The target drives SDA only through an active-high open-drain pull-down enable. Its 7-bit bus address combines four fixed upper bits with three strap inputs.

A write carries the following, in order:
- the address with the write bit,
- an index byte,
- a nonzero length byte,
- that many data bytes, which land in consecutive registers.

A read works differently. The host first writes the index byte. It then issues a repeated start and the address with the read bit. The target answers with a length byte giving how many implemented registers remain from the index. Register contents follow, and the host ends the read with a NACK and a stop.

The low bits of the register bank act as per-output enable bits. Each enable bit is combined with an active-low enable pin to form a registered clock-enable vector. The last two outputs share a single pin but keep separate register bits.

Top module: `smb_idx_slave`

## Requirements
- R1: The target acknowledges an address byte whose upper 7 bits equal {ADDR_HI, strap_i[2:0]}, where bit 0 is the direction (0 write, 1 read). On any other address it leaves SDA released until the next start condition.
- R2: In a write, the index byte and a nonzero length byte N are acknowledged. The next N data bytes are acknowledged and stored at registers index, index+1, and so on. Registers change only through such accepted bytes.
- R3: A length byte of 00h is not acknowledged. Every later byte up to the next start is neither acknowledged nor stored.
- R4: A data byte arriving after N bytes have been received is not acknowledged and is not stored.
- R5: A write data byte aimed at an index at or above NUM_REGS is acknowledged and discarded.
- R6: After a repeated start with the read bit, the target first sends the length byte. Its value is NUM_REGS minus the index, or 00h when the index is at or above NUM_REGS. After the host acknowledges it, the target sends register contents from the index upward, MSB first, with 00h for indexes at or above NUM_REGS.
- R7: A host NACK ends the read. A stop condition leaves SDA released and the target idle, ready for the next transaction.
- R8: The target changes its SDA drive only while synchronized SCL is low, except for the release forced by a start or stop.
- R9: After reset every register bit is 1. Each clk_en[i] is 1 exactly when register bit i (register i/8, bit i%8) is set and its enable pin is low. The result is registered.
- R10: Outputs NUM_OUT-2 and NUM_OUT-1 both take pin oe_pin_n[NUM_OUT-2], while each keeps its own register bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| strap_i | input | 3 | Low three address bits |
| oe_pin_n | input | NUM_OUT-1 | Active-low output enable pins; last pin serves the last two outputs |
| clk_en | output | NUM_OUT | Registered per-output enable |

## Verification
The assertions check several rules on every cycle:
- SDA drive moves only while SCL is low.
- A stop leaves SDA released and the target idle.
- The register bank holds still unless a write strobe fired.
- Every asserted clk_en traces back to a set register bit and a low pin one cycle earlier.

The bench scenarios cover what a property cannot see:
- every strap value with both matching and mismatching addresses,
- the returned length and first data byte for a sweep of indexes inside and past the bank,
- zero-length and over-length writes,
- early read termination,
- the shared pin of the last two outputs, checked against a model of the bank.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RACK, ST_TX, ST_TACK, ST_IGNORE
  } st_t;
  typedef enum logic [1:0] {
    KD_ADDR, KD_OFFS, KD_CNT, KD_DATA
  } kind_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter logic [7:0] RESET_VAL = 8'hFF,
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [7:0]              wdata,
  output logic [NUM_REGS*8-1:0]   regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_flat[g*8 +: 8] <= RESET_VAL;
      else if (we && (waddr == AW'(g)))
        regs_flat[g*8 +: 8] <= wdata;
    end
  end

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> $stable(regs_flat));
endmodule

// File: rtl/smb_out_gate.sv
module smb_out_gate #(
  parameter int NUM_OUT = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] en_bits,
  input  logic [NUM_OUT-2:0] oe_pin_n,
  output logic [NUM_OUT-1:0] clk_en
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    localparam int PIDX = (g > NUM_OUT - 2) ? NUM_OUT - 2 : g;
    always_ff @(posedge clk) begin
      if (rst) clk_en[g] <= 1'b0;
      else     clk_en[g] <= en_bits[g] & ~oe_pin_n[PIDX];
    end

    // R9 R10
    out_enable_chk: assert property (@(posedge clk) disable iff (rst)
      clk_en[g] |-> $past(en_bits[g] && !oe_pin_n[PIDX]));
  end
endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave
  import smb_idx_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b1101,
  parameter int         NUM_REGS    = 4,
  parameter int         NUM_OUT     = 12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [2:0]         strap_i,
  input  logic [NUM_OUT-2:0] oe_pin_n,
  output logic [NUM_OUT-1:0] clk_en
);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [NUM_REGS*8-1:0] regs_flat;
  logic [2:0] strap_q;
  st_t   state;
  kind_t kind;
  logic [7:0] shreg, txsh, ptr, remain;
  logic [3:0] bitcnt;
  logic go_tx, hack;
  logic in_bank, wr_fire, we;
  logic [7:0] avail, rd_byte, ptr_inc;
  logic [6:0] my_addr;

  smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .RESET_VAL(8'hFF)) bank_i (
    .clk(clk), .rst(rst), .we(we), .waddr(ptr[AW-1:0]), .wdata(shreg),
    .regs_flat(regs_flat));

  smb_out_gate #(.NUM_OUT(NUM_OUT)) gate_i (
    .clk(clk), .rst(rst), .en_bits(regs_flat[NUM_OUT-1:0]),
    .oe_pin_n(oe_pin_n), .clk_en(clk_en));

  always_comb begin
    my_addr = {ADDR_HI, strap_q};
    in_bank = ptr < 8'(NUM_REGS);
    avail   = in_bank ? 8'(NUM_REGS) - ptr : 8'h00;
    rd_byte = in_bank ? regs_flat[{ptr[AW-1:0], 3'b000} +: 8] : 8'h00;
    ptr_inc = (ptr == 8'hFF) ? ptr : ptr + 8'd1;
    wr_fire = (state == ST_RX) && scl_fall && (bitcnt == 4'd8) &&
              (kind == KD_DATA) && (remain != 8'd0) && !start_det && !stop_det;
    we      = wr_fire && in_bank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= 3'b000;
      state   <= ST_IDLE;
      kind    <= KD_ADDR;
      shreg   <= 8'h00;
      txsh    <= 8'h00;
      ptr     <= 8'h00;
      remain  <= 8'h00;
      bitcnt  <= 4'd0;
      go_tx   <= 1'b0;
      hack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      strap_q <= strap_i;
      if (start_det) begin
        state  <= ST_RX;
        kind   <= KD_ADDR;
        bitcnt <= 4'd0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= 4'd0;
              go_tx  <= 1'b0;
              unique case (kind)
                KD_ADDR: begin
                  if (shreg[7:1] == my_addr) begin
                    sda_oe <= 1'b1;
                    state  <= ST_RACK;
                    go_tx  <= shreg[0];
                    kind   <= KD_OFFS;
                  end else begin
                    state <= ST_IGNORE;
                  end
                end
                KD_OFFS: begin
                  ptr    <= shreg;
                  sda_oe <= 1'b1;
                  state  <= ST_RACK;
                  kind   <= KD_CNT;
                end
                KD_CNT: begin
                  if (shreg == 8'h00) begin
                    state <= ST_IGNORE;
                  end else begin
                    remain <= shreg;
                    sda_oe <= 1'b1;
                    state  <= ST_RACK;
                    kind   <= KD_DATA;
                  end
                end
                default: begin
                  if (remain == 8'h00) begin
                    state <= ST_IGNORE;
                  end else begin
                    remain <= remain - 8'd1;
                    ptr    <= ptr_inc;
                    sda_oe <= 1'b1;
                    state  <= ST_RACK;
                  end
                end
              endcase
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              if (go_tx) begin
                state  <= ST_TX;
                txsh   <= avail;
                sda_oe <= ~avail[7];
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                bitcnt <= 4'd0;
                sda_oe <= 1'b0;
                state  <= ST_TACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              hack <= ~sda_s;
            end else if (scl_fall) begin
              if (hack) begin
                txsh   <= rd_byte;
                sda_oe <= ~rd_byte[7];
                ptr    <= ptr_inc;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IGNORE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R8
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_det || stop_det)) |-> !$past(scl_s));

  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && state == ST_IDLE));

  // R1
  start_rx_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!sda_oe && state == ST_RX && kind == KD_ADDR));
endmodule

// File: tb/smb_idx_slave_tb_top.sv
module smb_idx_slave_tb_top;
  localparam int NREG = 4;
  localparam int NOUT = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drv_scl = 1'b1, drv_sda = 1'b1;
  logic [2:0] strap = 3'b000;
  logic [NOUT-2:0] pins = '0;
  logic sda_oe;
  logic [NOUT-1:0] clk_en;
  logic sda_line;
  logic [7:0] mdl [NREG];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = drv_sda & ~sda_oe;

  smb_idx_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(drv_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .oe_pin_n(pins), .clk_en(clk_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    drv_sda = 1'b1; q(); drv_scl = 1'b1; q(); drv_sda = 1'b0; q(); drv_scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    drv_sda = 1'b0; q(); drv_scl = 1'b1; q(); drv_sda = 1'b1; q(); q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      drv_sda = b[i]; q(); drv_scl = 1'b1; q(); q(); drv_scl = 1'b0; q();
    end
    drv_sda = 1'b1; q(); drv_scl = 1'b1; q(); ack = ~sda_line; q(); drv_scl = 1'b0; q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    b = 8'h00;
    drv_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q(); drv_scl = 1'b1; q(); b = {b[6:0], sda_line}; q(); drv_scl = 1'b0;
    end
    drv_sda = ~ack; q(); drv_scl = 1'b1; q(); q(); drv_scl = 1'b0; q();
    drv_sda = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    return (a < NREG) ? mdl[a] : 8'h00;
  endfunction

  function automatic logic [NOUT-1:0] exp_en();
    logic [NOUT-1:0] e;
    for (int i = 0; i < NOUT; i++) begin
      int p = (i > NOUT - 2) ? NOUT - 2 : i;
      e[i] = mdl[i / 8][i % 8] & ~pins[p];
    end
    return e;
  endfunction

  task automatic txn_write(input logic [7:0] off, input logic [7:0] cnt,
                           input int nsend, input logic [31:0] dat, input string req);
    logic ack;
    bus_start();
    send_byte({4'b1101, strap, 1'b0}, ack); chk({req, " addr ack"}, ack, 1);
    send_byte(off, ack); chk({req, " index ack"}, ack, 1);
    send_byte(cnt, ack); chk({req, " length ack"}, ack, (cnt != 0) ? 1 : 0);
    for (int k = 0; k < nsend; k++) begin
      bit take = (cnt != 0) && (k < cnt);
      send_byte(dat[k*8 +: 8], ack);
      chk({req, " data ack"}, ack, take ? 1 : 0);
      if (take && (int'(off) + k < NREG)) mdl[int'(off) + k] = dat[k*8 +: 8];
    end
    bus_stop();
  endtask

  task automatic txn_read(input logic [7:0] off, input int nrd, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({4'b1101, strap, 1'b0}, ack); chk({req, " addr ack"}, ack, 1);
    send_byte(off, ack); chk({req, " index ack"}, ack, 1);
    bus_start();
    send_byte({4'b1101, strap, 1'b1}, ack); chk({req, " read addr ack"}, ack, 1);
    recv_byte(b, 1'b1);
    chk({req, " length"}, b, (int'(off) < NREG) ? NREG - int'(off) : 0);
    for (int k = 0; k < nrd; k++) begin
      recv_byte(b, k < nrd - 1);
      chk({req, " data"}, b, exp_rd(int'(off) + k));
    end
    bus_stop();
    chk("R7 sda released after stop", sda_line, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'hFF;
    pins = 11'b101_0011_0101;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    // R9 reset state: all bits set, outputs follow pins
    chk("R9 reset enables", clk_en, exp_en());
    chk("R7 idle sda", sda_oe, 0);

    // R1 strap sweep: matching and mismatching address
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      repeat (4) @(negedge clk);
      bus_start();
      send_byte({4'b1101, 3'(s), 1'b0}, ack); chk("R1 match ack", ack, 1);
      bus_stop();
      bus_start();
      send_byte({4'b1101, 3'(s ^ 1), 1'b0}, ack); chk("R1 mismatch nack", ack, 0);
      send_byte(8'h00, ack); chk("R1 silent after mismatch", ack, 0);
      bus_stop();
    end
    strap = 3'b101;
    repeat (4) @(negedge clk);

    // R2 block write then read back; R6 count and data
    txn_write(8'h00, 8'h02, 2, 32'h0000_3CA5, "R2");
    txn_read(8'h00, 4, "R6");
    repeat (4) @(negedge clk);
    chk("R9 enables after write", clk_en, exp_en());

    // R6 sweep of indexes inside and past the bank
    for (int o = 0; o < 6; o++) txn_read(8'(o), 2, "R6 sweep");

    // R3 zero length rejected
    txn_write(8'h02, 8'h00, 2, 32'h0000_5511, "R3");
    txn_read(8'h02, 1, "R3 readback");

    // R4 bytes beyond N ignored
    txn_write(8'h03, 8'h01, 2, 32'h0000_2211, "R4");
    txn_read(8'h03, 1, "R4 readback");

    // R5 writes past the end acked and discarded
    txn_write(8'h03, 8'h03, 3, 32'h0099_8877, "R5");
    txn_read(8'h03, 2, "R5 readback");

    // R7 early stop after first data byte, then a fresh write works
    txn_read(8'h01, 1, "R7 early");
    txn_write(8'h02, 8'h01, 1, 32'h0000_00C3, "R7 next");
    txn_read(8'h02, 1, "R7 verify");

    // R10 shared pin for last two outputs, each with own bit
    txn_write(8'h01, 8'h01, 1, 32'h0000_0004, "R10 setup");
    for (int p = 0; p < 4; p++) begin
      pins = '0;
      pins[NOUT-2] = p[0];
      pins[NOUT-3] = p[1];
      repeat (4) @(negedge clk);
      chk("R10 shared pin", clk_en, exp_en());
    end
    txn_write(8'h01, 8'h01, 1, 32'h0000_0008, "R10 setup2");
    for (int p = 0; p < 2; p++) begin
      pins = '0;
      pins[NOUT-2] = p[0];
      repeat (4) @(negedge clk);
      chk("R10 own bit", clk_en, exp_en());
    end
    // R9 pin sweep with register pattern
    txn_write(8'h00, 8'h01, 1, 32'h0000_005A, "R9 setup");
    for (int v = 0; v < 16; v++) begin
      pins = 11'(v * 145);
      repeat (4) @(negedge clk);
      chk("R9 pin gating", clk_en, exp_en());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule